// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervision timer that runs from one core clock. Software loads a timeout and starts a down-counter. If software stops servicing it, the watchdog escalates in two steps. When the count first runs out, the block raises a level interrupt and restarts the count from the programmed timeout. If the count runs out again before software clears that interrupt, the block raises a system reset request. A control bit can hold back the reset request. Software then still gets the interrupt and can recover without a reboot.

Software uses a small register port with a write strobe, a 2-bit address and a 32-bit data word, plus a separate combinational read address. There are four registers:

- Address 0, timeout: read and write.
- Address 1, control: bit 0 starts the counter, bit 1 suppresses the reset request.
- Address 2, service: any write reloads the counter. A read returns the status, with bit 0 the interrupt and bit 1 the reset request.
- Address 3, live count: read only.

Top module: `wdt_two_stage`

## Requirements
- R1: After `rst_n` is low, `irq` and `sys_rst_req` are 0, and the live count (read address 3), the timeout and both control bits are 0.
- R2: While control bit 0 is 0 and no reload write occurs, the count holds its value and neither `irq` nor `sys_rst_req` becomes set.
- R3: While control bit 0 is 1 and the count is nonzero, the count decreases by one on every clock edge. Its live value is read at address 3.
- R4: On an enabled edge where the count is 0 and `irq` is clear, `irq` becomes 1 and the count reloads the timeout.
- R5: On an enabled edge where the count is 0 and `irq` is already 1, `sys_rst_req` becomes 1, as long as control bit 1 is 0. The count again reloads the timeout.
- R6: While control bit 1 is 1, `sys_rst_req` never becomes set, and `irq` still follows R4.
- R7: A write to address 0 stores the timeout, loads it into the count and clears `irq`. A write of any value to address 2 loads the stored timeout into the count and clears `irq`. A reload write takes priority over counting.
- R8: Clearing `irq` before the second expiry prevents the reset request. The next expiry then acts as a first stage.
- R9: Once `sys_rst_req` is 1, it stays 1 through any register write until `rst_n` is applied.
- R10: A timeout of 0 expires on the first enabled edge.
- R11: `irq` is a level that stays 1 until a reload write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | First-stage interrupt, level |
| sys_rst_req | output | 1 | Second-stage reset request, sticky |

## Verification
The bench uses several patterns:

- A full unserviced run tells the first-stage reload apart from the second-stage reset.
- The same run with suppression set shows that the interrupt still fires while the reset stays low.
- A service write between the two expiries shows that the stage sequence restarts instead of escalating.
- A zero timeout and an enable dropped mid-count separate the counting edge from the hold behaviour.
- A reload write while the interrupt is pending checks both the clear and the priority of the write.

// File: rtl/wdt_two_stage.sv
module wdt_two_stage #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic              irq,
  output logic              sys_rst_req
);
  localparam logic [ADDR_W-1:0] A_TMO  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SVC  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(3);

  logic [CNT_W-1:0] tmo_q, cnt_q;
  logic run_q, nrst_q, irq_q, rst_q;

  wire tmo_wr  = wr_en && (wr_addr == A_TMO);
  wire ctrl_wr = wr_en && (wr_addr == A_CTRL);
  wire svc_wr  = wr_en && (wr_addr == A_SVC);
  wire reload  = tmo_wr || svc_wr;
  wire zero    = (cnt_q == '0);
  wire expire  = run_q && zero && !reload;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmo_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      nrst_q <= 1'b0;
      irq_q  <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (tmo_wr) tmo_q <= wr_data;
      if (ctrl_wr) begin
        run_q  <= wr_data[0];
        nrst_q <= wr_data[1];
      end
      if (tmo_wr)      cnt_q <= wr_data;
      else if (svc_wr) cnt_q <= tmo_q;
      else if (run_q)  cnt_q <= zero ? tmo_q : cnt_q - 1'b1;
      if (reload)      irq_q <= 1'b0;
      else if (expire) irq_q <= 1'b1;
      if (expire && irq_q && !nrst_q) rst_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      A_TMO:   rd_data = tmo_q;
      A_CTRL:  rd_data = {{(CNT_W-2){1'b0}}, nrst_q, run_q};
      A_SVC:   rd_data = {{(CNT_W-2){1'b0}}, rst_q, irq_q};
      A_CNT:   rd_data = cnt_q;
      default: rd_data = '0;
    endcase
  end

  assign irq         = irq_q;
  assign sys_rst_req = rst_q;
endmodule

module wdt_two_stage_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              irq,
  input logic              sys_rst_req,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  tmo_q,
  input logic              run_q,
  input logic              nrst_q
);
  wire rl = wr_en && (wr_addr == ADDR_W'(0) || wr_addr == ADDR_W'(2));

  // R9
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |=> sys_rst_req);
  // R6
  rst_suppress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> !$past(nrst_q));
  // R5
  rst_needs_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_req) |-> $past(irq));
  // R2
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !rl) |=> (cnt_q == $past(cnt_q)) && !$rose(irq));
  // R3
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q != '0 && !rl) |=> cnt_q == $past(cnt_q) - 1'b1);
  // R4
  first_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && cnt_q == '0 && !irq && !rl) |=> irq && cnt_q == $past(tmo_q));
  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !rl) |=> irq);
endmodule

bind wdt_two_stage wdt_two_stage_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .irq(irq),
  .sys_rst_req(sys_rst_req), .cnt_q(cnt_q), .tmo_q(tmo_q), .run_q(run_q),
  .nrst_q(nrst_q)
);

// File: tb/sim_wdt_two_stage.sv
`timescale 1ns/1ps
module sim_wdt_two_stage;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = 2'd3;
  logic [31:0] rd_data;
  logic irq, sys_rst_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  int kq[$];
  logic [31:0] eq[$];
  string rq[$];

  always #4 clk = ~clk;

  wdt_two_stage u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .sys_rst_req(sys_rst_req)
  );

  task automatic push(input logic i, input logic r, input logic [31:0] c, input string req);
    kq.push_back(0); eq.push_back({31'd0, i}); rq.push_back(req);
    kq.push_back(1); eq.push_back({31'd0, r}); rq.push_back(req);
    kq.push_back(2); eq.push_back(c);          rq.push_back(req);
  endtask

  task automatic tick(input logic i, input logic r, input logic [31:0] c, input string req);
    push(i, r, c, req);
    @(negedge clk);
  endtask

  task automatic wr_chk(input logic [1:0] a, input logic [31:0] d,
                        input logic i, input logic r, input logic [31:0] c, input string req);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    push(i, r, c, req);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  always @(posedge clk) begin
    #2;
    while (kq.size() > 0) begin
      int k;
      logic [31:0] e, got;
      string r;
      k = kq.pop_front(); e = eq.pop_front(); r = rq.pop_front();
      got = (k == 0) ? {31'd0, irq} : (k == 1) ? {31'd0, sys_rst_req} : rd_data;
      checks++;
      if (got !== e) begin
        fails++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", r, k, got, e);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick(0, 0, 0, "R1");
    wr_chk(2'd0, 5, 0, 0, 5, "R7");
    repeat (3) tick(0, 0, 5, "R2");
    wr_chk(2'd1, 1, 0, 0, 5, "R2");
    for (int i = 1; i <= 5; i++) tick(0, 0, 5 - i, "R3");
    tick(1, 0, 5, "R4");
    for (int i = 1; i <= 5; i++) tick(1, 0, 5 - i, "R11");
    tick(1, 1, 5, "R5");
    wr_chk(2'd2, 0, 0, 1, 5, "R9");
    wr_chk(2'd1, 0, 0, 1, 4, "R9");
    tick(0, 1, 4, "R9");

    do_reset();
    tick(0, 0, 0, "R1");
    wr_chk(2'd0, 3, 0, 0, 3, "R7");
    wr_chk(2'd1, 3, 0, 0, 3, "R2");
    for (int i = 1; i <= 3; i++) tick(0, 0, 3 - i, "R3");
    tick(1, 0, 3, "R6");
    for (int i = 1; i <= 3; i++) tick(1, 0, 3 - i, "R6");
    tick(1, 0, 3, "R6");
    tick(1, 0, 2, "R6");
    wr_chk(2'd1, 1, 1, 0, 1, "R6");
    wr_chk(2'd2, 0, 0, 0, 3, "R8");
    for (int i = 1; i <= 3; i++) tick(0, 0, 3 - i, "R8");
    tick(1, 0, 3, "R8");
    for (int i = 1; i <= 3; i++) tick(1, 0, 3 - i, "R5");
    tick(1, 1, 3, "R5");

    do_reset();
    wr_chk(2'd1, 1, 0, 0, 0, "R10");
    tick(1, 0, 0, "R10");
    tick(1, 1, 0, "R10");

    do_reset();
    wr_chk(2'd0, 2, 0, 0, 2, "R7");
    wr_chk(2'd1, 1, 0, 0, 2, "R2");
    tick(0, 0, 1, "R3");
    wr_chk(2'd1, 0, 0, 0, 0, "R2");
    repeat (4) tick(0, 0, 0, "R2");
    wr_chk(2'd1, 1, 0, 0, 0, "R2");
    tick(1, 0, 2, "R4");
    wr_chk(2'd0, 7, 0, 0, 7, "R7");
    tick(0, 0, 6, "R3");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule